// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block connects a clocked on-chip request port to an external byte-wide static RAM with no clock of its own. The RAM has a 19-bit address, an 8-bit data bus and active-low chip select, write enable and output enable. The controller takes one read or write at a time through a valid/ready handshake. It sets the address and the strobes, and it controls the data-bus driver for a number of clock cycles. That number comes from the memory's timing limits given in picoseconds and the clock period, so the setup, pulse-width and hold rules of the memory are met at any clock rate.

The data bus is split into an output value, an output enable for the pad driver and an input value. The pad cell joins them outside the block. A read holds chip select and output enable low for the read-wait count. The byte is captured on the last wait cycle and returned with a one-cycle valid pulse. A write keeps output enable high for its whole length. Write enable falls one cycle after chip select. The controller turns on its driver only in the second cycle of the pulse and turns it off one cycle after write enable rises. So the memory's drivers are off before the controller drives the bus, and the data is held past the end of the write.

The state machine has seven states. IDLE has all strobes high and ready high. TURN is one cycle with chip select high, used only for a write that follows a read. RD_WAIT is the read strobe window. WR_SETUP has chip select low and write enable high. WE_LEAD is the first write-enable-low cycle, with the driver off. WE_DATA covers the write-enable-low cycles with the driver on. WR_HOLD has write enable high and the driver still on. The transitions are:
- IDLE to RD_WAIT on an accepted read.
- IDLE to WR_SETUP on an accepted write.
- IDLE to TURN on an accepted write after a read, then TURN to WR_SETUP.
- RD_WAIT to IDLE when its count expires.
- WR_SETUP to WE_LEAD, then WE_LEAD to WE_DATA.
- WE_DATA to WR_HOLD when its count expires.
- WR_HOLD to IDLE.

Top module: `sram_seq_ctrl`

## Requirements
- R1: During reset and in idle, chip select, write enable and output enable are all high (inactive), the data driver is off, rd_valid is low and req_ready is high.
- R2: A request is taken on a clock edge where req_valid and req_ready are both high. req_ready stays low from the next cycle until the controller is back in idle, and it is high in the cycle that carries rd_valid.
- R3: A read holds chip select low, output enable low and write enable high for exactly RD_CYC consecutive cycles, starting in the cycle after the request is taken.
- R4: Read data is sampled from the bus at the end of the last read-wait cycle. It is shown on rd_data in the next cycle, together with a rd_valid pulse exactly one cycle long.
- R5: Output enable stays high during every write. Chip select is low in the cycle before write enable falls and in the cycle after write enable rises.
- R6: Write enable is low for exactly 1 + DATA_CYC consecutive cycles per write, where DATA_CYC is the larger of DW_CYC and WP_CYC - 1. This is never fewer than WP_CYC.
- R7: The data driver is off in the first write-enable-low cycle and on in every later write-enable-low cycle and in the one cycle after write enable rises. It is off at all other times and the driven byte does not change while it is on. The request byte is what the memory stores.
- R8: The driver is never on while output enable is low, and output enable and write enable are never low at the same time.
- R9: A write taken right after a read gets one extra leading cycle with chip select high. A write after a write, or a read, gets no extra cycle.
- R10: RD_CYC, WP_CYC and DW_CYC are each the ceiling of the matching limit divided by CLK_PERIOD_PS, and each is at least 1.
- R11: The memory address does not change while chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write byte |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds read result |
| rd_data | output | DATA_W | Read result |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_o | output | DATA_W | Value for the data pad drivers |
| mem_dq_oe | output | 1 | Data pad driver enable, active high |
| mem_dq_i | input | DATA_W | Value seen at the data pads |

## Verification
The assertions assume that the requester holds req_valid and the request fields steady only across the accepting edge. They assume nothing about when a request arrives, because requests are sampled only in idle. They also assume that mem_dq_i is treated as stable only in the sampled read-wait cycle. The stimulus drives requests at falling edges, waits for req_ready, and drops req_valid after acceptance. The bench memory model returns a corrupted byte in every read-wait cycle except the last, so a read sampled early shows up as a data mismatch.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_RD_WAIT,
        ST_WR_SETUP,
        ST_WE_LEAD,
        ST_WE_DATA,
        ST_WR_HOLD
    } ctl_state_e;

    // R10: limit in ps to whole clock cycles, rounded up, never below one
    function automatic int unsigned cycles_for(input int unsigned limit_ps,
                                               input int unsigned period_ps);
        int unsigned c;
        c = (limit_ps + period_ps - 1) / period_ps;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/sram_cycle_cnt.sv
module sram_cycle_cnt #(
    parameter int unsigned CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W   = 19,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned RD_CYC   = 1,
    parameter int unsigned DATA_CYC = 1,
    parameter int unsigned CNT_W    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic              cnt_load,
    output logic [CNT_W-1:0]  cnt_val,
    input  logic              cnt_done
);
    ctl_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rvalid_q;
    logic              after_rd_q;
    logic              accept;

    assign accept = (state_q == ST_IDLE) && req_valid;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid)
                             state_d = !req_write ? ST_RD_WAIT :
                                       (after_rd_q ? ST_TURN : ST_WR_SETUP);
            ST_TURN:     state_d = ST_WR_SETUP;
            ST_RD_WAIT:  if (cnt_done) state_d = ST_IDLE;
            ST_WR_SETUP: state_d = ST_WE_LEAD;
            ST_WE_LEAD:  state_d = ST_WE_DATA;
            ST_WE_DATA:  if (cnt_done) state_d = ST_WR_HOLD;
            ST_WR_HOLD:  state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // counted states are loaded on entry with length minus one
    assign cnt_load = (state_d != state_q) &&
                      (state_d == ST_RD_WAIT || state_d == ST_WE_DATA);
    assign cnt_val  = (state_d == ST_RD_WAIT) ? CNT_W'(RD_CYC - 1)
                                              : CNT_W'(DATA_CYC - 1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request capture and read return
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q     <= '0;
            wdata_q    <= '0;
            rdata_q    <= '0;
            rvalid_q   <= 1'b0;
            after_rd_q <= 1'b0;
        end else begin
            if (accept) begin
                addr_q     <= req_addr;
                wdata_q    <= req_wdata;
                after_rd_q <= !req_write;
            end
            rvalid_q <= (state_q == ST_RD_WAIT) && cnt_done;
            if ((state_q == ST_RD_WAIT) && cnt_done)
                rdata_q <= mem_dq_i;
        end
    end

    // strobes decoded from state
    always_comb begin
        mem_cs_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_dq_oe = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_TURN: ;
            ST_RD_WAIT:  begin mem_cs_n = 1'b0; mem_oe_n = 1'b0; end
            ST_WR_SETUP: mem_cs_n = 1'b0;
            ST_WE_LEAD:  begin mem_cs_n = 1'b0; mem_we_n = 1'b0; end
            ST_WE_DATA:  begin mem_cs_n = 1'b0; mem_we_n = 1'b0; mem_dq_oe = 1'b1; end
            ST_WR_HOLD:  begin mem_cs_n = 1'b0; mem_dq_oe = 1'b1; end
            default: ;
        endcase
    end

    assign req_ready = (state_q == ST_IDLE);
    assign mem_addr  = addr_q;
    assign mem_dq_o  = wdata_q;
    assign rd_valid  = rvalid_q;
    assign rd_data   = rdata_q;

    // R8: no pad driver while the memory may drive
    a_r8_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);
    // R8: read and write strobes exclusive
    a_r8_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n));
    // R7: driver only after write enable has been low
    a_r7_drv_after_we: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> $past(!mem_we_n));
    // R7: driven byte steady
    a_r7_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_o));
    // R5: write enable only inside chip select
    a_r5_we_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_cs_n);
    // R4: valid is a single-cycle pulse
    a_r4_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    // R11: address steady under chip select
    a_r11_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));
    // R1: ready implies the memory is deselected
    a_r1_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && !mem_dq_oe));

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W        = 19,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned CLK_PERIOD_PS = 20000,
    parameter int unsigned T_RC_PS       = 10000,
    parameter int unsigned T_WP_PS       = 8000,
    parameter int unsigned T_DW_PS       = 6000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    localparam int unsigned RD_CYC   = cycles_for(T_RC_PS, CLK_PERIOD_PS);
    localparam int unsigned WP_CYC   = cycles_for(T_WP_PS, CLK_PERIOD_PS);
    localparam int unsigned DW_CYC   = cycles_for(T_DW_PS, CLK_PERIOD_PS);
    localparam int unsigned DATA_CYC = (DW_CYC > WP_CYC - 1) ? DW_CYC : WP_CYC - 1;
    localparam int unsigned MAX_CYC  = (RD_CYC > DATA_CYC) ? RD_CYC : DATA_CYC;
    localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_done;

    sram_cycle_cnt #(.CNT_W(CNT_W)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .done     (cnt_done)
    );

    sram_ctrl_fsm #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .RD_CYC   (RD_CYC),
        .DATA_CYC (DATA_CYC),
        .CNT_W    (CNT_W)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .mem_addr  (mem_addr),
        .mem_cs_n  (mem_cs_n),
        .mem_we_n  (mem_we_n),
        .mem_oe_n  (mem_oe_n),
        .mem_dq_o  (mem_dq_o),
        .mem_dq_oe (mem_dq_oe),
        .mem_dq_i  (mem_dq_i),
        .cnt_load  (cnt_load),
        .cnt_val   (cnt_val),
        .cnt_done  (cnt_done)
    );

endmodule

// File: tb/sram_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_seq_ctrl_tb_top;

    localparam int unsigned PER_PS = 20000;
    localparam int unsigned RC_PS  = 50000;
    localparam int unsigned WP_PS  = 70000;
    localparam int unsigned DW_PS  = 6000;

    function automatic int ceil_cyc(input int lim, input int per);
        int c;
        c = (lim + per - 1) / per;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int RD   = ceil_cyc(RC_PS, PER_PS);
    localparam int WP   = ceil_cyc(WP_PS, PER_PS);
    localparam int DW   = ceil_cyc(DW_PS, PER_PS);
    localparam int DATA = (DW > WP - 1) ? DW : WP - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [18:0] mem_addr;
    logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_o;
    logic [7:0]  mem_dq_i = '0;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    bit last_rd = 1'b0;

    logic [7:0] model_mem [int];
    logic [7:0] exp_mem [int];

    always #10 clk = ~clk;

    sram_seq_ctrl #(
        .CLK_PERIOD_PS (PER_PS),
        .T_RC_PS       (RC_PS),
        .T_WP_PS       (WP_PS),
        .T_DW_PS       (DW_PS)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] rd_model(input int a);
        return model_mem.exists(a) ? model_mem[a] : 8'h00;
    endfunction

    function automatic logic [7:0] rd_exp(input int a);
        return exp_mem.exists(a) ? exp_mem[a] : 8'h00;
    endfunction

    // behavioural memory: strobe widths in cycles, contention, storage
    int rd_cnt = 0;
    int we_w = 0;
    int dv_w = 0;
    int wa = 0;
    logic [7:0] last_d = '0;
    bit prev_cs_low = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_cs_n && !mem_oe_n && mem_we_n) begin
                rd_cnt++;
                mem_dq_i = (rd_cnt >= RD) ? rd_model(int'(mem_addr))
                                          : rd_model(int'(mem_addr)) ^ 8'hA5;
            end else begin
                if (rd_cnt != 0) chk(rd_cnt == RD, "R3 read strobe width", rd_cnt, RD);
                rd_cnt = 0;
                mem_dq_i = 8'h00;
            end
            if (mem_dq_oe && !mem_oe_n) chk(1'b0, "R8 bus contention", 1, 0);
            if (!mem_we_n && !mem_oe_n) chk(1'b0, "R5 oe low in write", 0, 1);
            if (!mem_we_n) begin
                if (we_w == 0) begin
                    chk(prev_cs_low && !mem_cs_n, "R5 cs before we", prev_cs_low, 1);
                    chk(!mem_dq_oe, "R7 driver off in first we cycle", mem_dq_oe, 0);
                end
                we_w++;
                wa = int'(mem_addr);
                if (mem_dq_oe) begin
                    dv_w++;
                    last_d = mem_dq_o;
                end
            end else if (we_w != 0) begin
                chk(we_w == 1 + DATA, "R6 we pulse width", we_w, 1 + DATA);
                chk(dv_w == we_w - 1 && dv_w >= DW, "R7 data window", dv_w, we_w - 1);
                chk(mem_dq_oe && !mem_cs_n && mem_dq_o == last_d, "R7 data hold",
                    {mem_dq_oe, mem_cs_n}, 2'b10);
                model_mem[wa] = last_d;
                we_w = 0;
                dv_w = 0;
            end else if (mem_dq_oe) begin
                chk(1'b0, "R7 driver outside write", 1, 0);
            end
            prev_cs_low = !mem_cs_n;
        end
    end

    task automatic wait_ready();
        while (!req_ready) @(negedge clk);
    endtask

    task automatic do_write(input logic [18:0] a, input logic [7:0] d);
        int n;
        bit turn;
        wait_ready();
        turn = last_rd;
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        chk(!req_ready, "R2 ready low after accept", req_ready, 0);
        chk(mem_cs_n == turn, "R9 turnaround cycle", mem_cs_n, turn);
        while (!req_ready) begin @(negedge clk); n++; end
        chk(n == DATA + 4 + int'(turn), "R9 write length", n, DATA + 4 + int'(turn));
        exp_mem[int'(a)] = d;
        last_rd = 1'b0;
    endtask

    task automatic do_read(input logic [18:0] a);
        int n;
        logic [7:0] e;
        wait_ready();
        e = rd_exp(int'(a));
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        chk(!mem_cs_n && !mem_oe_n && mem_we_n, "R3 read strobes",
            {mem_cs_n, mem_oe_n, mem_we_n}, 3'b001);
        while (!rd_valid && n < 50) begin @(negedge clk); n++; end
        chk(n == RD + 1, "R4 read latency", n, RD + 1);
        chk(rd_data == e, "R4 read data", rd_data, e);
        chk(req_ready, "R2 ready with valid", req_ready, 1);
        last_rd = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rd_valid,
            "R1 reset strobes", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && mem_cs_n && !mem_dq_oe, "R1 idle after reset",
            {req_ready, mem_cs_n}, 2'b11);
        chk(RD == 3 && WP == 4 && DW == 1, "R10 cycle derivation", RD * 100 + WP * 10 + DW, 341);
        // directed corners
        do_write(19'h00000, 8'h3C);
        do_read(19'h00000);
        do_write(19'h7FFFF, 8'hC3);
        do_write(19'h00001, 8'hFF);
        do_read(19'h7FFFF);
        do_read(19'h00001);
        do_read(19'h00005);
        // random mix
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 60; i++) begin
            logic [18:0] a;
            a = (($urandom % 8) == 0) ? 19'h7FFFF : 19'($urandom % 16);
            if ($urandom % 2) do_write(a, 8'($urandom));
            else              do_read(a);
        end
        repeat (2) @(negedge clk);
        chk(req_ready && mem_cs_n && mem_we_n && mem_oe_n, "R1 idle at end",
            {mem_cs_n, mem_we_n, mem_oe_n}, 3'b111);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule